// File: doc/BRIEF.md
# Shared-Bus Multicycle Instruction Sequencer

This block is the control and execution core of a small 8-bit processor. Program bytes and data bytes live in the same memory and reach the core through one synchronous port. That port has an address, a write-data bus, a read-data bus and separate read and write strobes. Every instruction walks through an ordered set of phases: instruction fetch, decode, operand fetch, execute and result write. The core keeps a program counter, an instruction register and a single working register, the accumulator, next to an 8-bit adder.

Because the single port carries both kinds of traffic, three bus cycles per memory instruction are unavoidable. The opcode, the direct-address byte and the data byte each occupy a separate bus cycle. The memory is expected to register its read data, so a byte requested in one cycle is consumed in the next. A halt opcode parks the core with the bus idle until reset.

Top module: `bus_seq_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter and the accumulator to zero, lowers `halted` and places the core in the fetch phase, so the first cycle after reset drives address 0 with `mem_rd` high.
- R2: `mem_rd` and `mem_wr` are never high in the same cycle. Each strobe is high for one cycle per access. Read data is taken from `mem_rdata` in the cycle after the read strobe.
- R3: An instruction that touches memory takes five cycles, one per phase in this order: opcode read at PC, address-byte read at PC+1 (decode), data access setup (operand), execute, write-back.
- R4: Opcode 0x73 adds the byte at the direct address held in the following byte to the accumulator, modulo 256, and writes the sum back into the accumulator.
- R5: Opcode 0x74 loads the accumulator with the byte at the direct address.
- R6: Opcode 0x75 writes the accumulator to the direct address with a single write cycle in the execute phase and leaves the accumulator unchanged.
- R7: The opcode sits at PC and its direct-address byte at PC+1. After a two-byte instruction the PC advances by 2, and after a one-byte instruction by 1.
- R8: Opcode 0x7F halts. `halted` rises two cycles after its fetch and stays high until reset, and no memory strobe is raised while halted.
- R9: Any other opcode is a one-byte no-op of two cycles that changes neither memory nor the accumulator.
- R10: Add and load make three reads each. Store makes two reads and one write. Halt and no-op make one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Shared memory address |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Registered read data from memory (valid the cycle after `mem_rd`) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High after a halt opcode until reset |

## Verification
The core's main function is exercised with a load–add–store–halt program run over a table of operand pairs. The pairs include small values, sums that wrap past 255, all-ones, two 0x80 bytes and zero plus zero. A correct sum separates the adder and the write-back path from a load that merely passes data through. The cycle count and the read and write tallies of each run expose any merged or missing bus cycle. Directed programs then place an undefined opcode first and store to the top address twice. They also assert reset after a halt and in mid-instruction, which tells a PC step error, an accumulator that a store or reset disturbs, and a halt that does not hold apart from the normal flow.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Instruction phases; the fetch phase must encode as zero.
    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_OPND   = 3'd2,
        PH_EXEC   = 3'd3,
        PH_WB     = 3'd4,
        PH_HALT   = 3'd5
    } phase_e;

    localparam logic [7:0] OPC_ADD  = 8'h73;
    localparam logic [7:0] OPC_LOAD = 8'h74;
    localparam logic [7:0] OPC_STOR = 8'h75;
    localparam logic [7:0] OPC_HALT = 8'h7F;

    // Control bundle produced by the opcode decoder.
    typedef struct packed {
        logic two_byte;  // opcode is followed by a direct-address byte
        logic rd_opnd;   // data byte is read from the direct address
        logic wr_opnd;   // accumulator is written to the direct address
        logic add;       // ALU adds instead of passing the operand
        logic halt;      // stop the sequencer
    } op_ctrl_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [7:0] opcode,
    output op_ctrl_t   ctl
);

    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_ADD: begin
                ctl.two_byte = 1'b1;
                ctl.rd_opnd  = 1'b1;
                ctl.add      = 1'b1;
            end
            OPC_LOAD: begin
                ctl.two_byte = 1'b1;
                ctl.rd_opnd  = 1'b1;
            end
            OPC_STOR: begin
                ctl.two_byte = 1'b1;
                ctl.wr_opnd  = 1'b1;
            end
            OPC_HALT: begin
                ctl.halt = 1'b1;
            end
            default: ctl = '0;  // undefined opcodes run as no-ops
        endcase
    end

endmodule

// File: rtl/seq_alu.sv
module seq_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          add_en,
    output logic [DW-1:0] y
);

    always_comb begin
        if (add_en) y = a + b;  // wraps modulo 2**DW
        else        y = b;
    end

endmodule

// File: rtl/seq_bus_ctl.sv
module seq_bus_ctl
    import seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  phase_e        phase,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] ar,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] acc,
    input  op_ctrl_t      ctl,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          rd,
    output logic          wr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // Steers the single shared port; exactly one user owns it per phase.
    always_comb begin
        addr  = pc;
        wdata = acc;
        rd    = 1'b0;
        wr    = 1'b0;
        unique case (phase)
            PH_FETCH: begin
                addr = pc;
                rd   = 1'b1;
            end
            PH_DECODE: begin
                if (ctl.two_byte) begin
                    addr = pc + ONE;
                    rd   = 1'b1;
                end
            end
            PH_OPND: begin
                if (ctl.rd_opnd) begin
                    addr = rdata[AW-1:0];
                    rd   = 1'b1;
                end
            end
            PH_EXEC: begin
                if (ctl.wr_opnd) begin
                    addr = ar;
                    wr   = 1'b1;
                end
            end
            PH_WB, PH_HALT: begin
                rd = 1'b0;
                wr = 1'b0;
            end
            default: begin
                rd = 1'b0;
                wr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bus_seq_core.sv
module bus_seq_core
    import seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          halted
);

    localparam logic [AW-1:0] STEP1 = AW'(1);
    localparam logic [AW-1:0] STEP2 = AW'(2);

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [AW-1:0] ar;
        logic [DW-1:0] r1;
        logic [DW-1:0] res;
    } core_st_t;

    core_st_t      st_d, st_q;
    logic [DW-1:0] dec_src;
    op_ctrl_t      ctl;
    logic [DW-1:0] alu_y;

    // In decode the opcode is still on the read bus; later it is in ir.
    assign dec_src = (st_q.phase == PH_DECODE) ? mem_rdata : st_q.ir;

    seq_decode u_dec (
        .opcode (dec_src[7:0]),
        .ctl    (ctl)
    );

    seq_alu #(.DW(DW)) u_alu (
        .a      (st_q.r1),
        .b      (mem_rdata),
        .add_en (ctl.add),
        .y      (alu_y)
    );

    seq_bus_ctl #(.AW(AW), .DW(DW)) u_bus (
        .phase (st_q.phase),
        .pc    (st_q.pc),
        .ar    (st_q.ar),
        .rdata (mem_rdata),
        .acc   (st_q.r1),
        .ctl   (ctl),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rd    (mem_rd),
        .wr    (mem_wr)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_FETCH: begin
                st_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                st_d.ir = mem_rdata;
                if (ctl.two_byte) begin
                    st_d.phase = PH_OPND;
                end else begin
                    st_d.pc    = st_q.pc + STEP1;
                    st_d.phase = ctl.halt ? PH_HALT : PH_FETCH;
                end
            end
            PH_OPND: begin
                st_d.ar    = mem_rdata[AW-1:0];
                st_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                if (ctl.rd_opnd) st_d.res = alu_y;
                st_d.phase = PH_WB;
            end
            PH_WB: begin
                if (ctl.rd_opnd) st_d.r1 = st_q.res;
                st_d.pc    = st_q.pc + STEP2;
                st_d.phase = PH_FETCH;
            end
            PH_HALT: begin
                st_d.phase = PH_HALT;
            end
            default: begin
                st_d.phase = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.phase <= PH_FETCH;
        end else begin
            st_q <= st_d;
        end
    end

    assign halted = (st_q.phase == PH_HALT);

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk
    import seq_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          halted,
    input phase_e        phase,
    input logic [AW-1:0] pc
);

    p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_rd && mem_addr == '0 && !halted));

    p_fetch_order_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));

    p_opnd_order_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPND) |=> (phase == PH_EXEC));

    p_exec_order_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_WB));

    p_write_in_exec_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (phase == PH_EXEC));

    p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WB) |=> (pc == AW'($past(pc) + AW'(2))));

    p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

endmodule

bind bus_seq_core seq_core_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .halted   (halted),
    .phase    (st_q.phase),
    .pc       (st_q.pc)
);

// File: tb/bus_seq_core_tb_top.sv
`timescale 1ns/1ps
module bus_seq_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_rd, mem_wr, halted;

    logic       ld_en = 1'b0;
    logic       clr   = 1'b0;
    logic [7:0] ld_addr = 8'h00;
    logic [7:0] ld_data = 8'h00;
    logic [7:0] mem [256];

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Operand pairs {a, b} for the load-add-store program.
    localparam logic [15:0] VEC [6] = '{
        16'h0102, 16'hF020, 16'hFFFF, 16'h8080, 16'h0000, 16'h7F01
    };

    always #2.5 clk = ~clk;

    bus_seq_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    // Behavioural memory with registered read data.
    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        ld_addr = a;
        ld_data = d;
        ld_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wipe();
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Releases reset at a negedge and runs until halted.
    task automatic run(output int cyc, output int nrd, output int nwr,
                       output logic [7:0] a0, output logic [7:0] a1, output logic [7:0] a2);
        cyc = 0; nrd = 0; nwr = 0;
        a0 = 8'hxx; a1 = 8'hxx; a2 = 8'hxx;
        rst = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (mem_rd) begin
                if (nrd == 0) a0 = mem_addr;
                if (nrd == 1) a1 = mem_addr;
                if (nrd == 2) a2 = mem_addr;
                nrd++;
            end
            if (mem_wr) nwr++;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
        end
        if (!halted) check(1'b0, "R8 run never halted", cyc, 0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int cyc, nrd, nwr;
        logic [7:0] a0, a1, a2;
        logic [7:0] va, vb, exp;

        hold_reset();
        // R1: reset state drives a fetch of address 0, halted low.
        check(mem_rd && mem_addr == 8'h00, "R1 reset fetch at 0", {mem_rd, mem_addr}, 9'h100);
        check(!halted && !mem_wr, "R1 halted low in reset", halted, 0);

        // Table walk: LD 0x40 ; ADD 0x41 ; ST 0x42 ; HALT
        for (int v = 0; v < 6; v++) begin
            va  = VEC[v][15:8];
            vb  = VEC[v][7:0];
            exp = va + vb;
            hold_reset();
            wipe();
            poke(8'h00, 8'h74); poke(8'h01, 8'h40);
            poke(8'h02, 8'h73); poke(8'h03, 8'h41);
            poke(8'h04, 8'h75); poke(8'h05, 8'h42);
            poke(8'h06, 8'h7F);
            poke(8'h40, va);    poke(8'h41, vb);
            run(cyc, nrd, nwr, a0, a1, a2);
            check(mem[8'h42] == exp, "R4 R5 load-add sum", mem[8'h42], exp);
            check(cyc == 17, "R3 R8 cycle count", cyc, 17);
            check(nrd == 9, "R10 read count", nrd, 9);
            check(nwr == 1, "R10 write count", nwr, 1);
            if (v == 0) begin
                check(a0 == 8'h00, "R7 opcode read at PC", a0, 8'h00);
                check(a1 == 8'h01, "R7 address byte at PC+1", a1, 8'h01);
                check(a2 == 8'h40, "R3 operand read at direct address", a2, 8'h40);
            end
        end

        // R8: halted holds and the bus stays idle.
        begin
            bit quiet = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!halted || mem_rd || mem_wr) quiet = 1'b0;
            end
            check(quiet, "R8 halt sticky and bus idle", quiet, 1);
        end

        // R1: reset after a halt with a nonzero accumulator clears it.
        hold_reset();
        check(!halted && mem_rd && mem_addr == 8'h00, "R1 reset clears halt", halted, 0);
        wipe();
        poke(8'h00, 8'h73); poke(8'h01, 8'h41);
        poke(8'h02, 8'h75); poke(8'h03, 8'h42);
        poke(8'h04, 8'h7F); poke(8'h41, 8'h11);
        run(cyc, nrd, nwr, a0, a1, a2);
        check(mem[8'h42] == 8'h11, "R1 accumulator cleared by reset", mem[8'h42], 8'h11);
        check(cyc == 12, "R3 cycle count add-store-halt", cyc, 12);

        // R1: reset in the middle of an instruction restarts at 0.
        hold_reset();
        rst = 1'b0;
        for (int k = 0; k < 7; k++) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(mem_rd && mem_addr == 8'h00 && !halted, "R1 mid-run reset", mem_addr, 0);
        run(cyc, nrd, nwr, a0, a1, a2);
        check(mem[8'h42] == 8'h11 && cyc == 12, "R1 rerun after mid-run reset", mem[8'h42], 8'h11);

        // R9: undefined opcode is a one-byte no-op.
        hold_reset();
        wipe();
        poke(8'h00, 8'hA5);
        poke(8'h01, 8'h74); poke(8'h02, 8'h40);
        poke(8'h03, 8'h75); poke(8'h04, 8'h42);
        poke(8'h05, 8'h7F); poke(8'h40, 8'h5A);
        run(cyc, nrd, nwr, a0, a1, a2);
        check(mem[8'h42] == 8'h5A, "R9 no-op then load-store", mem[8'h42], 8'h5A);
        check(cyc == 14, "R9 no-op takes two cycles", cyc, 14);
        check(nrd == 7 && nwr == 1, "R10 no-op one read", nrd, 7);
        check(a1 == 8'h01, "R7 PC steps by 1 after no-op", a1, 8'h01);
        check(mem[8'h00] == 8'hA5, "R9 memory unchanged by no-op", mem[8'h00], 8'hA5);

        // R6: store to the top address keeps the accumulator.
        hold_reset();
        wipe();
        poke(8'h00, 8'h74); poke(8'h01, 8'h40);
        poke(8'h02, 8'h75); poke(8'h03, 8'hFF);
        poke(8'h04, 8'h75); poke(8'h05, 8'h42);
        poke(8'h06, 8'h7F); poke(8'h40, 8'hC3);
        run(cyc, nrd, nwr, a0, a1, a2);
        check(mem[8'hFF] == 8'hC3, "R6 store to top address", mem[8'hFF], 8'hC3);
        check(mem[8'h42] == 8'hC3, "R6 accumulator unchanged by store", mem[8'h42], 8'hC3);
        check(mem[8'hFE] == 8'h00, "R6 neighbour untouched", mem[8'hFE], 8'h00);
        check(nwr == 2 && nrd == 8, "R10 store accesses", nwr, 2);
        check(cyc == 17, "R3 store cycle count", cyc, 17);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule